// File: doc/BRIEF.md
# Latency-Scheduled Writeback Issue Unit

This block is the issue and retirement core of a small microcoded floating-point sequencer. Each cycle in which `issue_valid` is high, it decodes one 32-bit microinstruction. It presents the two source registers on its operand outputs and produces a result. Simple bit-level operations are computed inside the block. For every other compute opcode the value on `ext_result` is used, which an arithmetic pipeline outside the block supplies in the same cycle. The result is parked in a circular result queue, in the slot that the head pointer reaches after exactly the opcode's latency.

Retirement is driven by the instruction stream itself. The destination field of the instruction issued in a cycle does not name where that instruction's own result goes. It names the register that receives the value leaving the queue head in that cycle. A program therefore places the destination of a result in a later instruction, counted by latency. The output-emit opcode ends a pass: it leaves the queue alone, returns the program counter to zero and pulses `pass_done`.

Top module: `sched_issue_unit`

## Requirements
- R1: `opnd_a` and `opnd_b` show, combinationally and whether or not an issue happens, the registers selected by instruction bits 24:18 and 17:11. Bits 10:7 carry the opcode and bits 6:0 carry the destination.
- R2: Opcodes are 0 NOP, 1 add, 2 subtract, 3 multiply, 4 abs, 5 float-to-int, 6 int-to-float, 7 emit, 8 sine, 9 cosine, 10 above, 11 equal, 12 copy, 13 select, 14 sign transfer, 15 rsqrt seed. Opcodes 1, 2, 3, 5, 6, 8, 9, 10 and 11 take `ext_result` in their issue cycle. A result of latency L is written by the L-th later advancing issue, into the register named by that issue's destination field. The latencies are: 1 and 2 → 5, 3 → 7, 6 → 3, 8 and 9 → 4, all others → 2.
- R3: When no result is due, a retiring issue writes zero, because every slot is cleared as the head leaves it.
- R4: A destination field of 0 writes nothing, and register 0 stays zero.
- R5: NOP (0) advances the queue and retires, but schedules nothing.
- R6: Abs (4) clears bit 31 of operand A. Copy (12) returns operand A unchanged.
- R7: Select (13) returns operand A when register 2 is nonzero, and operand B otherwise.
- R8: Sign transfer (14) flips bit 31 of A only when B has bit 31 set and a nonzero magnitude. Negative zero counts as not below zero.
- R9: The rsqrt seed (15) returns 0x5F3759DF minus operand A shifted right by one.
- R10: Emit (7) retires nothing, leaves the queue unmoved and sets the PC to 0. `pass_done` is high for the one cycle after the emit issue.
- R11: With `issue_valid` low, PC, queue and registers hold.
- R12: Every non-emit issue increments the PC by one.
- R13: A synchronous reset clears the PC, the head pointer, all queue slots, all registers and `pass_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is issued this cycle |
| insn | input | 32 | Microinstruction at the current PC |
| ext_result | input | 32 | Result from the external arithmetic units, for the current instruction |
| pc | output | PC_W | Program counter |
| opnd_a | output | 32 | Register selected by bits 24:18 |
| opnd_b | output | 32 | Register selected by bits 17:11 |
| pass_done | output | 1 | One-cycle strobe after an emit |

## Verification
No port writes the register file, so no data can be placed in a register directly. The only way in is a scheduled result that a later instruction retires, with the correct offset. The stimulus loads each register this way: it issues an add carrying the wanted value on `ext_result`, followed by four empty NOPs and a NOP whose destination names the register. Contents are read back through the operand outputs while no issue takes place. The hardest cases are overlapping results of different latencies, and an emit placed exactly on the cycle where a result is due. Both are built from this same loading scheme, with destinations chosen at every offset.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int WORD_W    = 32;
  localparam int REG_IDX_W = 7;
  localparam int NUM_REGS  = 1 << REG_IDX_W;
  localparam int MAX_LAT   = 7;
  localparam int LAT_W     = $clog2(MAX_LAT + 1);
  localparam logic [WORD_W-1:0] RSQ_MAGIC = 32'h5F37_59DF;

  typedef enum logic [3:0] {
    OP_IDLE = 4'd0,  OP_ADD  = 4'd1,  OP_SUB    = 4'd2,  OP_MUL = 4'd3,
    OP_ABS  = 4'd4,  OP_FTOI = 4'd5,  OP_ITOF   = 4'd6,  OP_EMIT = 4'd7,
    OP_SINE = 4'd8,  OP_COSINE = 4'd9, OP_GT    = 4'd10, OP_EQ  = 4'd11,
    OP_MOVE = 4'd12, OP_SEL  = 4'd13, OP_SGN    = 4'd14, OP_RSQ = 4'd15
  } op_e;

  typedef struct packed {
    logic [6:0]           spare;
    logic [REG_IDX_W-1:0] src_a;
    logic [REG_IDX_W-1:0] src_b;
    op_e                  op;
    logic [REG_IDX_W-1:0] dst;
  } insn_t;

  function automatic logic [LAT_W-1:0] op_latency(op_e op);
    case (op)
      OP_IDLE, OP_EMIT:    return LAT_W'(0);
      OP_ADD, OP_SUB:      return LAT_W'(5);
      OP_MUL:              return LAT_W'(7);
      OP_ITOF:             return LAT_W'(3);
      OP_SINE, OP_COSINE:  return LAT_W'(4);
      default:             return LAT_W'(2);
    endcase
  endfunction

  function automatic logic op_is_local(op_e op);
    return (op == OP_ABS) || (op == OP_MOVE) || (op == OP_SEL) ||
           (op == OP_SGN) || (op == OP_RSQ);
  endfunction

  function automatic logic [WORD_W-1:0] f_abs(logic [WORD_W-1:0] a);
    return {1'b0, a[WORD_W-2:0]};
  endfunction

  function automatic logic [WORD_W-1:0] f_select(logic [WORD_W-1:0] flag,
                                                 logic [WORD_W-1:0] a,
                                                 logic [WORD_W-1:0] b);
    return (flag != '0) ? a : b;
  endfunction

  function automatic logic [WORD_W-1:0] f_sign_xfer(logic [WORD_W-1:0] a,
                                                    logic [WORD_W-1:0] b);
    logic neg;
    neg = b[WORD_W-1] && (b[WORD_W-2:0] != '0);
    return {a[WORD_W-1] ^ neg, a[WORD_W-2:0]};
  endfunction

  function automatic logic [WORD_W-1:0] f_rsqrt_seed(logic [WORD_W-1:0] a);
    return RSQ_MAGIC - (a >> 1);
  endfunction
endpackage

// File: rtl/sched_decode.sv
module sched_decode
  import sched_pkg::*;
(
  input  logic [WORD_W-1:0]    insn,
  output op_e                  op,
  output logic [REG_IDX_W-1:0] src_a,
  output logic [REG_IDX_W-1:0] src_b,
  output logic [REG_IDX_W-1:0] dst,
  output logic [LAT_W-1:0]     lat,
  output logic                 is_emit,
  output logic                 schedules,
  output logic                 is_local
);
  insn_t f;
  logic  unused_spare;

  assign f            = insn_t'(insn);
  assign unused_spare = ^f.spare;
  assign op           = f.op;
  assign src_a        = f.src_a;
  assign src_b        = f.src_b;
  assign dst          = f.dst;
  assign lat          = op_latency(f.op);
  assign is_emit      = (f.op == OP_EMIT);
  assign schedules    = (f.op != OP_IDLE) && (f.op != OP_EMIT);
  assign is_local     = op_is_local(f.op);
endmodule

// File: rtl/sched_regfile.sv
module sched_regfile #(
  parameter int N_ENTRIES = 128,
  parameter int DATA_W    = 32,
  parameter int FLAG_IDX  = 2,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_a,
  input  logic [IDX_W-1:0]  ridx_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  output logic [DATA_W-1:0] flag_val,
  output logic [DATA_W-1:0] zero_val
);
  logic [DATA_W-1:0] mem [N_ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENTRIES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata_a  = mem[ridx_a];
  assign rdata_b  = mem[ridx_b];
  assign flag_val = mem[FLAG_IDX];
  assign zero_val = mem[0];
endmodule

// File: rtl/sched_result_queue.sv
module sched_result_queue #(
  parameter int DEPTH  = 7,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 3,
  localparam int HEAD_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              insert,
  input  logic [LAT_W-1:0]  lat,
  input  logic [DATA_W-1:0] ins_data,
  output logic [DATA_W-1:0] head_data,
  output logic [HEAD_W-1:0] head_idx
);
  logic [DATA_W-1:0] slot [DEPTH];
  logic [HEAD_W-1:0] head_q;
  logic [HEAD_W-1:0] head_nxt;
  logic [HEAD_W:0]   ins_sum;
  logic [HEAD_W-1:0] ins_idx;

  // landing slot: head after this advance plus (lat - 1), i.e. head + lat mod DEPTH
  always_comb begin
    ins_sum = {1'b0, head_q} + (HEAD_W+1)'(lat);
    if (ins_sum >= (HEAD_W+1)'(DEPTH)) ins_sum = ins_sum - (HEAD_W+1)'(DEPTH);
    ins_idx  = ins_sum[HEAD_W-1:0];
    head_nxt = (head_q == HEAD_W'(DEPTH-1)) ? '0 : head_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (advance) begin
      slot[head_q] <= '0;
      if (insert) slot[ins_idx] <= ins_data;
      head_q <= head_nxt;
    end
  end

  assign head_data = slot[head_q];
  assign head_idx  = head_q;
endmodule

// File: rtl/sched_issue_unit.sv
module sched_issue_unit
  import sched_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int DEPTH = MAX_LAT,
  localparam int HEAD_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [31:0]       insn,
  input  logic [31:0]       ext_result,
  output logic [PC_W-1:0]   pc,
  output logic [31:0]       opnd_a,
  output logic [31:0]       opnd_b,
  output logic              pass_done
);
  op_e                  dec_op;
  logic [REG_IDX_W-1:0] dec_a, dec_b, dec_dst;
  logic [LAT_W-1:0]     dec_lat;
  logic                 dec_emit, dec_sched, dec_local;

  // named events for the checker
  logic                 adv_fire;
  logic                 emit_fire;
  logic                 retire_we;
  logic [HEAD_W-1:0]    head_idx;
  logic [31:0]          zero_val;

  logic [31:0]          flag_val;
  logic [31:0]          head_data;
  logic [31:0]          local_res;
  logic [31:0]          issue_res;
  logic [PC_W-1:0]      pc_q;
  logic                 done_q;

  sched_decode u_dec (
    .insn      (insn),
    .op        (dec_op),
    .src_a     (dec_a),
    .src_b     (dec_b),
    .dst       (dec_dst),
    .lat       (dec_lat),
    .is_emit   (dec_emit),
    .schedules (dec_sched),
    .is_local  (dec_local)
  );

  assign adv_fire  = issue_valid && !dec_emit;
  assign emit_fire = issue_valid && dec_emit;
  assign retire_we = adv_fire && (dec_dst != '0);

  sched_regfile #(
    .N_ENTRIES (NUM_REGS),
    .DATA_W    (WORD_W),
    .FLAG_IDX  (2)
  ) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (retire_we),
    .widx     (dec_dst),
    .wdata    (head_data),
    .ridx_a   (dec_a),
    .ridx_b   (dec_b),
    .rdata_a  (opnd_a),
    .rdata_b  (opnd_b),
    .flag_val (flag_val),
    .zero_val (zero_val)
  );

  always_comb begin
    case (dec_op)
      OP_ABS:  local_res = f_abs(opnd_a);
      OP_SEL:  local_res = f_select(flag_val, opnd_a, opnd_b);
      OP_SGN:  local_res = f_sign_xfer(opnd_a, opnd_b);
      OP_RSQ:  local_res = f_rsqrt_seed(opnd_a);
      default: local_res = opnd_a;
    endcase
    issue_res = dec_local ? local_res : ext_result;
  end

  sched_result_queue #(
    .DEPTH  (DEPTH),
    .DATA_W (WORD_W),
    .LAT_W  (LAT_W)
  ) u_q (
    .clk       (clk),
    .rst       (rst),
    .advance   (adv_fire),
    .insert    (dec_sched),
    .lat       (dec_lat),
    .ins_data  (issue_res),
    .head_data (head_data),
    .head_idx  (head_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= emit_fire;
      if (emit_fire)     pc_q <= '0;
      else if (adv_fire) pc_q <= pc_q + 1'b1;
    end
  end

  assign pc        = pc_q;
  assign pass_done = done_q;
endmodule

// File: rtl/sched_issue_chk.sv
module sched_issue_chk #(
  parameter int PC_W   = 11,
  parameter int DEPTH  = 7,
  parameter int HEAD_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_valid,
  input logic              adv_fire,
  input logic              emit_fire,
  input logic [PC_W-1:0]   pc,
  input logic [HEAD_W-1:0] head_idx,
  input logic              pass_done,
  input logic [31:0]       zero_val
);
  assert_pc_step_R12: assert property (@(posedge clk) disable iff (rst)
    adv_fire |=> pc == $past(pc) + 1'b1);

  assert_head_step_R2: assert property (@(posedge clk) disable iff (rst)
    adv_fire |=> head_idx == (($past(head_idx) == HEAD_W'(DEPTH-1)) ?
                              HEAD_W'(0) : $past(head_idx) + 1'b1));

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> $stable(pc) && $stable(head_idx) && !pass_done);

  assert_emit_pass_R10: assert property (@(posedge clk) disable iff (rst)
    emit_fire |=> pass_done && (pc == '0) && $stable(head_idx));

  assert_reg_zero_R4: assert property (@(posedge clk) disable iff (rst)
    zero_val == 32'd0);

  assert_reset_clear_R13: assert property (@(posedge clk)
    rst |=> (pc == '0) && (head_idx == '0) && !pass_done);
endmodule

bind sched_issue_unit sched_issue_chk #(
  .PC_W   (PC_W),
  .DEPTH  (DEPTH),
  .HEAD_W (HEAD_W)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .adv_fire    (adv_fire),
  .emit_fire   (emit_fire),
  .pc          (pc),
  .head_idx    (head_idx),
  .pass_done   (pass_done),
  .zero_val    (zero_val)
);

// File: tb/test_sched_issue_unit.sv
module test_sched_issue_unit;
  import sched_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] ext_result = '0;
  logic [10:0] pc;
  logic [31:0] opnd_a, opnd_b;
  logic        pass_done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sched_issue_unit i_sched_issue_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .insn(insn),
    .ext_result(ext_result), .pc(pc), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .pass_done(pass_done)
  );

  function automatic logic [31:0] mk(logic [3:0] op, logic [6:0] a, logic [6:0] b, logic [6:0] d);
    return {7'd0, a, b, op, d};
  endfunction

  function automatic int lat_of(logic [3:0] op);
    case (op)
      4'd1, 4'd2: return 5;
      4'd3:       return 7;
      4'd6:       return 3;
      4'd8, 4'd9: return 4;
      default:    return 2;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w, logic [31:0] ext);
    @(negedge clk);
    insn = w; ext_result = ext; issue_valid = 1'b1;
    @(posedge clk);
    #1;
    issue_valid = 1'b0;
  endtask

  task automatic peek(logic [6:0] r, output logic [31:0] v);
    insn = mk(4'd0, r, 7'd0, 7'd0);
    issue_valid = 1'b0;
    #1;
    v = opnd_a;
  endtask

  // value enters the queue via add (lat 5) and is retired by the 5th NOP
  task automatic load_reg(logic [6:0] r, logic [31:0] v);
    issue(mk(4'd1, 7'd0, 7'd0, 7'd0), v);
    for (int k = 1; k < 5; k++) issue(mk(4'd0, 7'd0, 7'd0, 7'd0), 32'hDEAD_0000);
    issue(mk(4'd0, 7'd0, 7'd0, r), '0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R13 pc after reset", 32'(pc), 32'd0);
    chk("R13 pass_done after reset", 32'(pass_done), 32'd0);
    peek(7'd2, v);   chk("R13 reg2 after reset", v, 32'd0);
    peek(7'd127, v); chk("R13 reg127 after reset", v, 32'd0);
  endtask

  task automatic t_pc;
    logic [10:0] p0;
    p0 = pc;
    for (int k = 0; k < 3; k++) issue(mk(4'd0, 7'd0, 7'd0, 7'd0), '0);
    chk("R12 pc after 3 issues", 32'(pc), 32'(p0 + 11'd3));
  endtask

  task automatic t_operands;
    logic [31:0] v;
    load_reg(7'd20, 32'h1234_5678);
    load_reg(7'd21, 32'h9ABC_DEF0);
    insn = mk(4'd0, 7'd21, 7'd20, 7'd0); #1;
    chk("R1 opnd_a from bits 24:18", opnd_a, 32'h9ABC_DEF0);
    chk("R1 opnd_b from bits 17:11", opnd_b, 32'h1234_5678);
    peek(7'd20, v);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    logic [3:0] ops [9] = '{4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10, 4'd11};
    foreach (ops[i]) begin
      logic [31:0] tag;
      int L;
      tag = 32'hA500_0000 | 32'(ops[i]);
      L = lat_of(ops[i]);
      issue(mk(ops[i], 7'd0, 7'd0, 7'd0), tag);
      for (int k = 1; k <= 7; k++) issue(mk(4'd0, 7'd0, 7'd0, 7'(99 + k)), '0);
      for (int k = 1; k <= 7; k++) begin
        peek(7'(99 + k), v);
        chk($sformatf("R2 op %0d offset %0d", ops[i], k), v, (k == L) ? tag : 32'd0);
      end
    end
  endtask

  task automatic run_local(string tag, logic [3:0] op, logic [6:0] a, logic [6:0] b, logic [31:0] exp);
    logic [31:0] v;
    issue(mk(op, a, b, 7'd0), 32'hFFFF_FFFF);
    issue(mk(4'd0, 7'd0, 7'd0, 7'd0), '0);
    issue(mk(4'd0, 7'd0, 7'd0, 7'd60), '0);
    peek(7'd60, v);
    chk(tag, v, exp);
  endtask

  task automatic t_local_ops;
    load_reg(7'd22, 32'hC049_0FDB);
    load_reg(7'd23, 32'h4000_0000);
    load_reg(7'd24, 32'h8000_0000);
    load_reg(7'd25, 32'hBF80_0000);
    run_local("R6 abs clears sign", 4'd4, 7'd22, 7'd0, 32'h4049_0FDB);
    run_local("R6 copy", 4'd12, 7'd22, 7'd0, 32'hC049_0FDB);
    run_local("R9 rsqrt seed", 4'd15, 7'd23, 7'd0, 32'h3F37_59DF);
    run_local("R8 sign xfer negative B", 4'd14, 7'd23, 7'd25, 32'hC000_0000);
    run_local("R8 sign xfer negative zero B", 4'd14, 7'd23, 7'd24, 32'h4000_0000);
    run_local("R8 sign xfer positive B", 4'd14, 7'd22, 7'd23, 32'hC049_0FDB);
    run_local("R7 select flag zero", 4'd13, 7'd22, 7'd23, 32'h4000_0000);
    load_reg(7'd2, 32'h0000_0001);
    run_local("R7 select flag set", 4'd13, 7'd22, 7'd23, 32'hC049_0FDB);
  endtask

  task automatic t_dest_zero;
    logic [31:0] v;
    issue(mk(4'd1, 7'd0, 7'd0, 7'd0), 32'h7777_7777);
    for (int k = 1; k <= 5; k++) issue(mk(4'd0, 7'd0, 7'd0, 7'd0), '0);
    peek(7'd0, v);
    chk("R4 dest 0 not written", v, 32'd0);
  endtask

  task automatic t_empty_and_nop;
    logic [31:0] v;
    load_reg(7'd30, 32'h5555_AAAA);
    issue(mk(4'd0, 7'd0, 7'd0, 7'd30), '0);
    peek(7'd30, v);
    chk("R3 empty slot retires zero", v, 32'd0);
    issue(mk(4'd0, 7'd0, 7'd0, 7'd0), 32'h1111_1111);
    for (int k = 1; k <= 7; k++) issue(mk(4'd0, 7'd0, 7'd0, 7'(30 + k)), '0);
    for (int k = 1; k <= 7; k++) begin
      peek(7'(30 + k), v);
      chk($sformatf("R5 nop schedules nothing offset %0d", k), v, 32'd0);
    end
  endtask

  task automatic t_overlap;
    logic [31:0] v;
    logic [31:0] exp [8];
    issue(mk(4'd3, 7'd0, 7'd0, 7'd0), 32'hCAFE_0003);
    issue(mk(4'd1, 7'd0, 7'd0, 7'd71), 32'hCAFE_0001);
    issue(mk(4'd12, 7'd22, 7'd0, 7'd72), '0);
    for (int k = 3; k <= 7; k++) issue(mk(4'd0, 7'd0, 7'd0, 7'(70 + k)), '0);
    exp = '{32'd0, 32'd0, 32'd0, 32'd0, 32'hC049_0FDB, 32'd0, 32'hCAFE_0001, 32'hCAFE_0003};
    for (int k = 1; k <= 7; k++) begin
      peek(7'(70 + k), v);
      chk($sformatf("R2 overlap offset %0d", k), v, exp[k]);
    end
  endtask

  task automatic t_stall;
    logic [31:0] v;
    logic [10:0] p0;
    p0 = pc;
    @(negedge clk);
    insn = mk(4'd1, 7'd0, 7'd0, 7'd0); ext_result = 32'hBAD0_BAD0; issue_valid = 1'b0;
    @(posedge clk); #1;
    chk("R11 pc holds on stall", 32'(pc), 32'(p0));
    for (int k = 1; k <= 7; k++) issue(mk(4'd0, 7'd0, 7'd0, 7'(40 + k)), '0);
    for (int k = 1; k <= 7; k++) begin
      peek(7'(40 + k), v);
      chk($sformatf("R11 stalled insn not scheduled offset %0d", k), v, 32'd0);
    end
  endtask

  task automatic t_emit;
    logic [31:0] v;
    issue(mk(4'd1, 7'd0, 7'd0, 7'd0), 32'h0BAD_F00D);
    for (int k = 1; k < 5; k++) issue(mk(4'd0, 7'd0, 7'd0, 7'd0), '0);
    issue(mk(4'd7, 7'd0, 7'd0, 7'd51), '0);
    chk("R10 pc cleared by emit", 32'(pc), 32'd0);
    chk("R10 pass_done after emit", 32'(pass_done), 32'd1);
    issue(mk(4'd0, 7'd0, 7'd0, 7'd52), '0);
    chk("R10 pass_done one cycle", 32'(pass_done), 32'd0);
    peek(7'd51, v);
    chk("R10 emit retires nothing", v, 32'd0);
    peek(7'd52, v);
    chk("R10 queue not advanced by emit", v, 32'h0BAD_F00D);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_pc();
    t_operands();
    t_latency();
    t_local_ops();
    t_dest_zero();
    t_empty_and_nop();
    t_overlap();
    t_stall();
    t_emit();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule